// File: doc/BRIEF.md
# Credit-Based Round-Robin Memory Arbiter

This block lets up to eight job sources share one request channel into a memory controller. Each source presents jobs with a valid/ready handshake. At any moment at most one source owns the channel, and that source gets all of the controller's throughput. The owner's job data and valid are steered onto the single output channel. The controller's ready is returned only to the owner.

Ownership works by tenure, not by single request. A newly chosen owner may keep the channel for up to `CREDITS` consecutive cycles, for as long as it keeps its valid high. Every owned cycle uses one credit, whether the job is accepted or stalled by the controller.

When the budget runs out, the channel moves on. It also moves on the moment the owner stops requesting. The next owner is the first requesting source after the previous owner, in ascending index order with wrap-around. Idle sources are never selected, so no cycle is lost on a source with nothing to send. `CREDITS` is an elaboration parameter and cannot change at run time.

Top module: `credit_rr_arbiter`

## Requirements
- R1: After reset, and in any cycle where no port has `reqValid` high, `grant`, `reqReady` and `memValid` are all zero.
- R2: In every cycle at most one bit of `grant` is high. Bit i of `grant` means port i owns the channel.
- R3: A port whose `reqValid` is low never has its `grant` bit high in that cycle.
- R4: In any cycle where at least one port has `reqValid` high, exactly one port is granted in that same cycle.
- R5: A port that is granted with its `reqValid` held high keeps the grant for exactly `CREDITS` consecutive cycles (default 4). Cycles stalled by `memReady` low count toward this budget.
- R6: When the budget is spent, the grant passes to the first requesting port after the owner, in ascending index order with wrap from port N-1 to port 0. If the owner is the only requester, it starts a new tenure immediately.
- R7: If the owner drops `reqValid`, the grant moves to the next requesting port in that same cycle.
- R8: While no port requests, the search position is kept. The next grant goes to the first requester after the last owner.
- R9: The first search after reset starts at port 0.
- R10: `memData` equals the granted port's slice `reqData[i*DATA_W +: DATA_W]`, and `memValid` is high whenever a port is granted. `reqReady` equals `memReady` for the granted port and is 0 for every other port.
- R11: With all eight ports requesting continuously, every port is granted exactly `CREDITS` cycles in each window of 8*`CREDITS` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Per-port job valid |
| reqData | input | NUM_PORTS*DATA_W | Per-port job words, port i at bits i*DATA_W upward |
| reqReady | output | NUM_PORTS | Per-port job accept |
| grant | output | NUM_PORTS | One-hot owner indication |
| memValid | output | 1 | Job valid toward the controller |
| memData | output | DATA_W | Job word toward the controller |
| memReady | input | 1 | Controller accepts the job |

## Verification
The hardest situations to reach from the ports are the hand-overs. One is a tenure that ends because its budget runs out while other ports are still requesting. Another is an owner that drops its request partway through a tenure. A third is a gap with no requesters, after which the search must resume from the remembered position rather than from port 0. Directed sequences start from reset, so the owner and search position are known. They then shape the valid pattern cycle by cycle to force each hand-over, with the controller ready toggled to show that stalled cycles still use credits. A seeded random load then checks every cycle that the grant is one-hot, goes only to a requester, and is never absent while someone requests. A fully loaded run checks the per-port share of cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int MAX_PORTS = 8;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic                 grantAny;
    logic [IDX_W-1:0]     grantIdx;
    logic [MAX_PORTS-1:0] grantVec;
  } grant_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl #(
  parameter int NUM_PORTS = 8,
  parameter int CREDITS   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] reqValid,
  output arb_pkg::grant_t      strobe
);
  import arb_pkg::*;
  localparam int CNT_W = $clog2(CREDITS + 1);

  logic [IDX_W-1:0] curOwner;
  logic             held;
  logic [CNT_W-1:0] used;

  logic             keep;
  logic             pickFound;
  logic [IDX_W-1:0] pickIdx;
  logic [IDX_W-1:0] grantIdx;
  logic             grantAny;

  // tenure continues while the owner still requests and has budget left
  assign keep = held && reqValid[curOwner] && (used != CNT_W'(CREDITS));

  // round-robin search starting just after the last owner
  always_comb begin
    logic [IDX_W:0] cand;
    pickFound = 1'b0;
    pickIdx   = '0;
    cand      = '0;
    for (int off = 1; off <= NUM_PORTS; off++) begin
      cand = {1'b0, curOwner} + (IDX_W+1)'(off);
      if (cand >= (IDX_W+1)'(NUM_PORTS)) cand = cand - (IDX_W+1)'(NUM_PORTS);
      if (!pickFound && reqValid[cand[IDX_W-1:0]]) begin
        pickFound = 1'b1;
        pickIdx   = cand[IDX_W-1:0];
      end
    end
  end

  assign grantIdx = keep ? curOwner : pickIdx;
  assign grantAny = keep || pickFound;

  always_comb begin
    strobe.grantAny = grantAny;
    strobe.grantIdx = grantIdx;
    for (int i = 0; i < MAX_PORTS; i++)
      strobe.grantVec[i] = grantAny && (i < NUM_PORTS) && (grantIdx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curOwner <= IDX_W'(NUM_PORTS - 1);
      held     <= 1'b0;
      used     <= '0;
    end else if (grantAny) begin
      curOwner <= grantIdx;
      held     <= 1'b1;
      used     <= keep ? used + CNT_W'(1) : CNT_W'(1);
    end else begin
      held     <= 1'b0;
      used     <= '0;
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.grantVec));
  // R3
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.grantVec[NUM_PORTS-1:0] & ~reqValid) == '0);
  // R4
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|reqValid) |-> strobe.grantAny);
  // R5
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CNT_W'(CREDITS));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !reqValid[curOwner] && (|reqValid)) |-> (strobe.grantIdx != curOwner));
  // R8
  token_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.grantAny |=> $stable(curOwner));
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath #(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  arb_pkg::grant_t             strobe,
  input  logic [NUM_PORTS*DATA_W-1:0] reqData,
  input  logic                        memReady,
  output logic [NUM_PORTS-1:0]        reqReady,
  output logic                        memValid,
  output logic [DATA_W-1:0]           memData
);
  assign memValid = strobe.grantAny;
  assign memData  = strobe.grantAny ? reqData[int'(strobe.grantIdx)*DATA_W +: DATA_W] : '0;
  assign reqReady = strobe.grantVec[NUM_PORTS-1:0] & {NUM_PORTS{memReady}};

  // R10
  accept_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && memReady) |-> ($countones(reqReady) == 1));
  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memValid |-> (reqReady == '0));
endmodule

// File: rtl/credit_rr_arbiter.sv
module credit_rr_arbiter #(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 32,
  parameter int CREDITS   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [NUM_PORTS*DATA_W-1:0] reqData,
  output logic [NUM_PORTS-1:0]        reqReady,
  output logic [NUM_PORTS-1:0]        grant,
  output logic                        memValid,
  output logic [DATA_W-1:0]           memData,
  input  logic                        memReady
);
  arb_pkg::grant_t strobe;

  arb_ctrl #(.NUM_PORTS(NUM_PORTS), .CREDITS(CREDITS)) ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .strobe(strobe));

  arb_datapath #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqData(reqData),
    .memReady(memReady), .reqReady(reqReady), .memValid(memValid),
    .memData(memData));

  assign grant = strobe.grantVec[NUM_PORTS-1:0];
endmodule

// File: tb/credit_rr_arbiter_test.sv
module credit_rr_arbiter_test;
  localparam int N = 8;
  localparam int W = 32;
  localparam int CR = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   reqValid = '0;
  logic [N*W-1:0] reqData;
  logic [N-1:0]   reqReady;
  logic [N-1:0]   grant;
  logic           memValid;
  logic [W-1:0]   memData;
  logic           memReady = 1'b1;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  credit_rr_arbiter #(.NUM_PORTS(N), .DATA_W(W), .CREDITS(CR)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqData(reqData),
    .reqReady(reqReady), .grant(grant), .memValid(memValid),
    .memData(memData), .memReady(memReady));

  initial for (int i = 0; i < N; i++) reqData[i*W +: W] = 32'hA500_0000 + i * 32'h11;

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance one cycle, apply new valid pattern, then settle before sampling
  task automatic cycleWith(logic [N-1:0] v);
    @(negedge clk);
    reqValid = v;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    reqValid = '0;
    memReady = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    checkEq("R1 reset grant", 32'(grant), 0);
    checkEq("R1 reset memValid", 32'(memValid), 0);
    checkEq("R1 reset reqReady", 32'(reqReady), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic testBudget();
    doReset();
    reqValid = 8'h28; #1;
    for (int c = 0; c < CR; c++) begin
      checkEq("R9/R5 tenure port3", 32'(grant), 32'h08);
      cycleWith(8'h28);
    end
    for (int c = 0; c < CR; c++) begin
      checkEq("R6/R5 tenure port5", 32'(grant), 32'h20);
      cycleWith(8'h28);
    end
    checkEq("R6 wrap back to port3", 32'(grant), 32'h08);
  endtask

  task automatic testRelease();
    doReset();
    reqValid = 8'h44; #1;
    checkEq("R9 port2 first", 32'(grant), 32'h04);
    cycleWith(8'h44);
    checkEq("R5 port2 keeps", 32'(grant), 32'h04);
    cycleWith(8'h40);
    checkEq("R7 immediate release to port6", 32'(grant), 32'h40);
    checkEq("R3 idle port2 ungranted", 32'(grant[2]), 0);
  endtask

  task automatic testTokenHold();
    doReset();
    reqValid = 8'h20; #1;
    checkEq("R4 port5 granted", 32'(grant), 32'h20);
    cycleWith(8'h20);
    for (int c = 0; c < 3; c++) begin
      cycleWith(8'h00);
      checkEq("R1 no requests no grant", 32'(grant), 0);
      checkEq("R1 no requests memValid", 32'(memValid), 0);
    end
    cycleWith(8'h42);
    checkEq("R8 search resumes after port5", 32'(grant), 32'h40);
  endtask

  task automatic testSoleRequester();
    doReset();
    reqValid = 8'h01; #1;
    for (int c = 0; c < 3 * CR; c++) begin
      checkEq("R6 sole requester regains", 32'(grant), 32'h01);
      cycleWith(8'h01);
    end
  endtask

  task automatic testDataPath();
    doReset();
    memReady = 1'b0;
    reqValid = 8'h12; #1;
    checkEq("R10 memData port1", memData, 32'hA500_0011);
    checkEq("R10 memValid", 32'(memValid), 1);
    checkEq("R10 stalled reqReady", 32'(reqReady), 0);
    @(negedge clk); memReady = 1'b1; #1;
    checkEq("R10 reqReady to owner", 32'(reqReady), 32'h02);
    @(negedge clk); memReady = 1'b0; #1;
    @(negedge clk); memReady = 1'b1; #1;
    checkEq("R5 still port1 on last credit", 32'(grant), 32'h02);
    @(negedge clk); #1;
    checkEq("R5 stalls consumed credits", 32'(grant), 32'h10);
    checkEq("R10 memData port4", memData, 32'hA500_0044);
    checkEq("R10 reqReady port4", 32'(reqReady), 32'h10);
  endtask

  task automatic testFairness();
    int cnt[N];
    doReset();
    foreach (cnt[i]) cnt[i] = 0;
    reqValid = '1; #1;
    for (int c = 0; c < N * CR * 2; c++) begin
      for (int i = 0; i < N; i++) if (grant[i]) cnt[i]++;
      if (c < N * CR) checkEq("R11 ordered rotation", 32'(grant), 32'(1) << (c / CR));
      cycleWith('1);
    end
    for (int i = 0; i < N; i++) checkEq("R11 equal share", 32'(cnt[i]), 2 * CR);
  endtask

  task automatic testRandom();
    int dummy;
    doReset();
    dummy = $urandom(1234);
    for (int c = 0; c < 400; c++) begin
      cycleWith(N'($urandom) & N'($urandom));
      memReady = 1'($urandom);
      #0.5;
      checkEq("R2 onehot grant", 32'($countones(grant) <= 1), 1);
      checkEq("R3 idle never granted", 32'(grant & ~reqValid), 0);
      checkEq("R4 work conserving", 32'(|grant), 32'(|reqValid));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testBudget();
    testRelease();
    testTokenHold();
    testSoleRequester();
    testDataPath();
    testFairness();
    testRandom();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule